// File: doc/BRIEF.md
# Sector Text Uploader

This block reads a stored disk-cartridge image one sector at a time and turns it into readable ASCII text for a serial transmitter. A `start` pulse begins a walk over the whole geometry. The cylinder number is the outermost loop, then the head, then the sector. For each sector the block fetches words from a word-addressed buffer memory through a request/valid read port. It emits a header line, one line per data word, and a trailer line that reports the sector's error flags.

The text leaves through a byte-wide valid/ready stream into a UART transmitter that runs at 921600 baud. Back-pressure rules:
- Once `tx_valid` is high, it stays high and `tx_data` stays fixed until a cycle in which `tx_ready` is also high.
- A byte moves only in a cycle where both signals are high.
- The transmitter may hold `tx_ready` low for any length of time, and the walk simply pauses.

Memory reads are paced by the text. A new read is requested only after the line for the previous word has been fully accepted, so at most one read is ever in flight.

When the trailer of the last sector has been accepted, `done` pulses for one cycle and the block returns to idle.

Top module: `sector_text_uploader`

## Requirements
- R1: After `start` in idle, the block emits a record for every sector (CYL_COUNT x HEAD_COUNT x SECT_COUNT of them) in this order: sector increments fastest, then head, then cylinder.
- R2: A record's first line is the cylinder, head and sector numbers in decimal without leading zeros, separated by single spaces (0x20), then CR (0x0D) LF (0x0A). Every emitted byte is printable ASCII, CR or LF.
- R3: Words 0 to WORDS_PER_SECT-1 of the sector each produce one line. Each line is four uppercase hex digits, most significant first, then CR LF. The word is read at `rd_addr` = {cylinder, head, sector, word}, with the word index in the low WW bits, then the sector in SW bits, then the head in HW bits, then the cylinder.
- R4: The trailer uses the word at index WORDS_PER_SECT. Bit 0 is the sync error and bit 1 is the data error; all other bits are ignored. With both bits clear the line is "OK". Otherwise it is "ERR", then " SYNC" if bit 0 is set, then " DATA" if bit 1 is set. The line ends with CR LF.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high in the next cycle and `tx_data` is unchanged.
- R6: `rd_req` is a one-cycle pulse. It is never high together with `tx_valid`, and a read is issued only after the previous line has been fully accepted.
- R7: `done` is high for exactly one cycle. That cycle is the one right after the last trailer byte is accepted. Afterwards the block stays idle, with no `tx_valid` and no `rd_req`.
- R8: A `start` pulse during a walk has no effect on the emitted text.
- R9: During reset, and in the cycle after it, `tx_valid`, `rd_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a walk from idle |
| done | output | 1 | One-cycle pulse after the final trailer |
| rd_req | output | 1 | Read request pulse to the image memory |
| rd_addr | output | CW+HW+SW+WW | Read address {cylinder, head, sector, word}; each field is $clog2 of its count (word: of WORDS_PER_SECT+1) |
| rd_valid | input | 1 | Read data valid, one cycle per request |
| rd_data | input | DATA_W | Read data word |
| tx_valid | output | 1 | Text byte valid |
| tx_ready | input | 1 | Transmitter can accept a byte |
| tx_data | output | 8 | ASCII text byte |

## Verification
The assertions take the following for granted about the inputs:
- The memory answers each `rd_req` with exactly one `rd_valid`, after any latency of at least one cycle.
- No `rd_valid` arrives without a request.
- `tx_ready` may change freely, but only between clock edges.

The bench memory model queues a single pending answer per request, with a latency of one to four cycles taken from an LFSR. The same LFSR withholds `tx_ready` in about a quarter of cycles. A second `start` is pulsed mid-walk, and a reset is applied in the middle of a later walk.

// File: rtl/stu_pkg.sv
package stu_pkg;
  typedef enum logic [1:0] {LN_HEAD, LN_WORD, LN_TAIL} line_kind_e;
  typedef enum logic [2:0] {S_IDLE, S_SEND, S_RREQ, S_RWAIT, S_FIN} walk_state_e;

  localparam logic [7:0] ASC_CR = 8'h0D;
  localparam logic [7:0] ASC_LF = 8'h0A;
  localparam logic [7:0] ASC_SP = 8'h20;

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  function automatic logic [7:0] dec_ascii(input int unsigned d);
    return 8'h30 + 8'(d);
  endfunction
endpackage

// File: rtl/stu_wrap_ctr.sv
module stu_wrap_ctr #(
  parameter int unsigned LIMIT = 2,
  parameter int unsigned W     = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         at_max
);
  assign at_max = (q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (inc)    q <= at_max ? '0 : q + 1'b1;
  end
endmodule

// File: rtl/stu_line_fmt.sv
module stu_line_fmt
  import stu_pkg::*;
#(
  parameter int unsigned CYL_W    = 8,
  parameter int unsigned HEAD_W   = 1,
  parameter int unsigned SECT_W   = 2,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LINE_MAX = 16,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned LEN_W    = 5
) (
  input  line_kind_e                  kind,
  input  logic [CYL_W-1:0]            cyl,
  input  logic [HEAD_W-1:0]           head,
  input  logic [SECT_W-1:0]           sect,
  input  logic [DATA_W-1:0]           word,
  output logic [LINE_MAX-1:0][7:0]    bytes,
  output logic [LEN_W-1:0]            len
);
  localparam int unsigned NIB = DATA_W / 4;

  logic [NIB-1:0][7:0] hexc;
  for (genvar g = 0; g < NIB; g++) begin : g_hex
    assign hexc[g] = hex_ascii(word[DATA_W-1-4*g -: 4]);
  end

  always_comb begin
    logic [IDX_W-1:0] n;
    int unsigned cv;
    cv    = 32'(cyl);
    bytes = '0;
    n     = '0;
    unique case (kind)
      LN_HEAD: begin
        if (cv >= 100) begin bytes[n] = dec_ascii(cv / 100); n = n + 1'b1; end
        if (cv >= 10)  begin bytes[n] = dec_ascii((cv / 10) % 10); n = n + 1'b1; end
        bytes[n] = dec_ascii(cv % 10);     n = n + 1'b1;
        bytes[n] = ASC_SP;                 n = n + 1'b1;
        bytes[n] = dec_ascii(32'(head));   n = n + 1'b1;
        bytes[n] = ASC_SP;                 n = n + 1'b1;
        bytes[n] = dec_ascii(32'(sect));   n = n + 1'b1;
      end
      LN_WORD: begin
        for (int i = 0; i < NIB; i++) bytes[i] = hexc[i];
        n = IDX_W'(NIB);
      end
      default: begin
        if (!word[0] && !word[1]) begin
          bytes[0] = "O"; bytes[1] = "K"; n = IDX_W'(2);
        end else begin
          bytes[0] = "E"; bytes[1] = "R"; bytes[2] = "R"; n = IDX_W'(3);
          if (word[0]) begin
            bytes[n] = ASC_SP; n = n + 1'b1; bytes[n] = "S"; n = n + 1'b1;
            bytes[n] = "Y";    n = n + 1'b1; bytes[n] = "N"; n = n + 1'b1;
            bytes[n] = "C";    n = n + 1'b1;
          end
          if (word[1]) begin
            bytes[n] = ASC_SP; n = n + 1'b1; bytes[n] = "D"; n = n + 1'b1;
            bytes[n] = "A";    n = n + 1'b1; bytes[n] = "T"; n = n + 1'b1;
            bytes[n] = "A";    n = n + 1'b1;
          end
        end
      end
    endcase
    bytes[n]                = ASC_CR;
    bytes[IDX_W'(n + 1'b1)] = ASC_LF;
    len = LEN_W'(n) + LEN_W'(2);
  end
endmodule

// File: rtl/stu_byte_tx.sv
module stu_byte_tx #(
  parameter int unsigned LINE_MAX = 16,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned LEN_W    = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     tx_ready,
  input  logic [LINE_MAX-1:0][7:0] bytes,
  input  logic [LEN_W-1:0]         len,
  output logic                     tx_valid,
  output logic [7:0]               tx_data,
  output logic                     last_acc
);
  logic [IDX_W-1:0] idx;
  logic             fire, at_end;

  assign tx_valid = en;
  assign tx_data  = bytes[idx];
  assign fire     = en && tx_ready;
  assign at_end   = (LEN_W'(idx) == len - LEN_W'(1));
  assign last_acc = fire && at_end;

  always_ff @(posedge clk) begin
    if (rst || !en)  idx <= '0;
    else if (fire)   idx <= at_end ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/sector_text_uploader.sv
module sector_text_uploader
  import stu_pkg::*;
#(
  parameter int unsigned CYL_COUNT      = 203,
  parameter int unsigned HEAD_COUNT     = 2,
  parameter int unsigned SECT_COUNT     = 4,
  parameter int unsigned WORDS_PER_SECT = 321,
  parameter int unsigned DATA_W         = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        done,
  output logic        rd_req,
  output logic [$clog2(CYL_COUNT)+$clog2(HEAD_COUNT)+$clog2(SECT_COUNT)
                +$clog2(WORDS_PER_SECT+1)-1:0] rd_addr,
  input  logic        rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data
);
  localparam int unsigned CYL_W    = $clog2(CYL_COUNT);
  localparam int unsigned HEAD_W   = $clog2(HEAD_COUNT);
  localparam int unsigned SECT_W   = $clog2(SECT_COUNT);
  localparam int unsigned WORD_W   = $clog2(WORDS_PER_SECT + 1);
  localparam int unsigned NIB      = DATA_W / 4;
  localparam int unsigned LINE_MAX = (NIB + 2 > 16) ? NIB + 2 : 16;
  localparam int unsigned IDX_W    = $clog2(LINE_MAX);
  localparam int unsigned LEN_W    = $clog2(LINE_MAX + 1);

  walk_state_e             state;
  line_kind_e              kind;
  logic [WORD_W-1:0]       word_idx;
  logic [DATA_W-1:0]       word_q;
  logic [CYL_W-1:0]        cyl;
  logic [HEAD_W-1:0]       head;
  logic [SECT_W-1:0]       sect;
  logic                    cyl_max, head_max, sect_max, geo_last;
  logic                    walk_clr, walk_step, last_acc;
  logic [LINE_MAX-1:0][7:0] line_bytes;
  logic [LEN_W-1:0]        line_len;

  assign walk_clr  = (state == S_IDLE) && start;
  assign geo_last  = cyl_max && head_max && sect_max;
  assign walk_step = last_acc && (kind == LN_TAIL) && !geo_last;

  stu_wrap_ctr #(.LIMIT(SECT_COUNT), .W(SECT_W)) u_sect (
    .clk(clk), .rst(rst), .clr(walk_clr), .inc(walk_step),
    .q(sect), .at_max(sect_max));
  stu_wrap_ctr #(.LIMIT(HEAD_COUNT), .W(HEAD_W)) u_head (
    .clk(clk), .rst(rst), .clr(walk_clr), .inc(walk_step && sect_max),
    .q(head), .at_max(head_max));
  stu_wrap_ctr #(.LIMIT(CYL_COUNT), .W(CYL_W)) u_cyl (
    .clk(clk), .rst(rst), .clr(walk_clr), .inc(walk_step && sect_max && head_max),
    .q(cyl), .at_max(cyl_max));

  stu_line_fmt #(
    .CYL_W(CYL_W), .HEAD_W(HEAD_W), .SECT_W(SECT_W), .DATA_W(DATA_W),
    .LINE_MAX(LINE_MAX), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_fmt (
    .kind(kind), .cyl(cyl), .head(head), .sect(sect), .word(word_q),
    .bytes(line_bytes), .len(line_len));

  stu_byte_tx #(.LINE_MAX(LINE_MAX), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst(rst), .en(state == S_SEND), .tx_ready(tx_ready),
    .bytes(line_bytes), .len(line_len),
    .tx_valid(tx_valid), .tx_data(tx_data), .last_acc(last_acc));

  assign rd_req  = (state == S_RREQ);
  assign rd_addr = {cyl, head, sect, word_idx};
  assign done    = (state == S_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind     <= LN_HEAD;
      word_idx <= '0;
      word_q   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_SEND;
          kind  <= LN_HEAD;
        end
        S_SEND: if (last_acc) begin
          unique case (kind)
            LN_HEAD: begin word_idx <= '0;              state <= S_RREQ; end
            LN_WORD: begin word_idx <= word_idx + 1'b1; state <= S_RREQ; end
            default: begin
              if (geo_last) state <= S_FIN;
              else          kind  <= LN_HEAD;
            end
          endcase
        end
        S_RREQ: state <= S_RWAIT;
        S_RWAIT: if (rd_valid) begin
          word_q <= rd_data;
          kind   <= (word_idx == WORD_W'(WORDS_PER_SECT)) ? LN_TAIL : LN_WORD;
          state  <= S_SEND;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stu_checker.sv
module stu_checker (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic       rd_req,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data
);
  p_text_only_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ((tx_data == 8'h0D) || (tx_data == 8'h0A) ||
                  (tx_data >= 8'h20 && tx_data <= 8'h7E)));

  p_hold_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> tx_valid);

  p_hold_data_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> $stable(tx_data));

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && tx_valid));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!tx_valid && !rd_req));

  p_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_valid && !rd_req && !done));
endmodule

bind sector_text_uploader stu_checker u_chk (
  .clk(clk), .rst(rst), .done(done), .rd_req(rd_req),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data));

// File: tb/sector_text_uploader_test.sv
module sector_text_uploader_test;
  localparam int NC = 102, NH = 2, NS = 2, NW = 8, DW = 16;
  localparam int WW = $clog2(NW + 1), SW = $clog2(NS), HW = $clog2(NH), CW = $clog2(NC);
  localparam int AW = CW + HW + SW + WW;
  localparam int LIMIT = 190000;

  typedef struct packed { logic [15:0] w; logic [31:0] txt; } vec_t;
  localparam vec_t VEC [8] = '{
    '{16'h0000, "0000"}, '{16'hFFFF, "FFFF"}, '{16'h00A5, "00A5"}, '{16'h1234, "1234"},
    '{16'hABCD, "ABCD"}, '{16'h8000, "8000"}, '{16'h0F0F, "0F0F"}, '{16'h7FFE, "7FFE"}};

  logic clk = 0, rst = 1, start = 0, done, rd_req, rd_valid = 0, tx_valid, tx_ready = 0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic [7:0]    tx_data;

  always #2 clk = ~clk;

  sector_text_uploader #(.CYL_COUNT(NC), .HEAD_COUNT(NH), .SECT_COUNT(NS),
                         .WORDS_PER_SECT(NW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .start(start), .done(done), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data));

  int n_chk = 0, n_fail = 0, cyc = 0, rx_cnt = 0, done_cnt = 0, rx_at_done = -1, total = 0;
  bit mon_on = 1, pend = 0;
  int lat = 0;
  logic [15:0] lfsr = 16'hACE1, pend_data = '0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] cap [128];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(int c, int h, int s, int w);
    if (w == NW) return 16'hFFFC | 16'((c + 2 * h + s) % 4);
    if (c == 0 && h == 0 && s == 0) return VEC[w].w;
    return 16'((c * 40503) ^ (h * 9973) ^ (s * 4099) ^ (w * 24593) ^ 16'h5A3C);
  endfunction

  function automatic logic [7:0] hx(logic [3:0] n);
    return (n < 10) ? 8'h30 + 8'(n) : 8'h37 + 8'(n);
  endfunction

  task automatic push_line(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) begin exp_q.push_back(s[i]); tag_q.push_back(tag); end
    exp_q.push_back(8'h0D); tag_q.push_back(tag);
    exp_q.push_back(8'h0A); tag_q.push_back(tag);
  endtask

  // Reference text: R1 order, R2 header, R3 words, R4 trailer
  task automatic build_model();
    for (int c = 0; c < NC; c++)
      for (int h = 0; h < NH; h++)
        for (int s = 0; s < NS; s++) begin
          logic [15:0] st, d;
          string t;
          push_line($sformatf("%0d %0d %0d", c, h, s), "R1 R2");
          for (int w = 0; w < NW; w++) begin
            d = mem_word(c, h, s, w);
            t = "";
            for (int k = 3; k >= 0; k--) t = {t, string'(hx(d[4*k +: 4]))};
            push_line(t, "R3");
          end
          st = mem_word(c, h, s, NW);
          if (st[1:0] == 2'b00) t = "OK";
          else t = {"ERR", st[0] ? " SYNC" : "", st[1] ? " DATA" : ""};
          push_line(t, "R4");
        end
    total = exp_q.size();
  endtask

  // Per-cycle driver and monitor
  initial forever begin
    @(negedge clk);
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = (lfsr[1:0] != 2'b00);
    if (pend && lat == 0) begin rd_valid = 1; rd_data = pend_data; pend = 0; end
    else begin rd_valid = 0; if (pend) lat--; end
    #1;
    if (rd_req) begin
      pend = 1;
      lat = int'(lfsr[4:3]);
      pend_data = mem_word(int'(rd_addr[AW-1 -: CW]), int'(rd_addr[WW+SW +: HW]),
                           int'(rd_addr[WW +: SW]), int'(rd_addr[WW-1:0]));
    end
    if (mon_on && tx_valid && tx_ready) begin
      if (rx_cnt < 128) cap[rx_cnt] = tx_data;
      if (exp_q.size() == 0) chk(0, "R1", "extra byte", tx_data, 0);
      else begin
        logic [7:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(tx_data == e, tg, $sformatf("byte %0d", rx_cnt), tx_data, e);
      end
      rx_cnt++;
    end
    if (mon_on && done) begin done_cnt++; rx_at_done = rx_cnt; end
  end

  initial begin
    build_model();
    repeat (4) @(negedge clk);
    #1;
    chk(!tx_valid, "R9", "tx_valid in reset", tx_valid, 0);
    chk(!rd_req,   "R9", "rd_req in reset",   rd_req, 0);
    chk(!done,     "R9", "done in reset",     done, 0);
    @(negedge clk); rst = 0;
    repeat (3) @(negedge clk);
    #1 chk(!tx_valid && !rd_req, "R9", "idle without start", tx_valid, 0);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (rx_cnt < 500 && cyc < LIMIT) @(negedge clk);
    // R8: second start mid-walk must leave the stream unchanged
    start = 1;
    @(negedge clk); start = 0;
    while (done_cnt == 0 && cyc < LIMIT) @(negedge clk);
    if (cyc >= LIMIT) chk(0, "R7", "watchdog expired", cyc, LIMIT);
    repeat (20) begin
      @(negedge clk);
      #1 chk(!tx_valid && !rd_req, "R7", "idle after done", tx_valid, 0);
    end
    chk(rx_cnt == total, "R1", "total bytes", rx_cnt, total);
    chk(exp_q.size() == 0, "R1", "missing bytes", exp_q.size(), 0);
    chk(done_cnt == 1, "R7", "done cycles", done_cnt, 1);
    chk(rx_at_done == total, "R7", "done after last byte", rx_at_done, total);
    chk(cap[0] == "0" && cap[4] == "0" && cap[5] == 8'h0D, "R2", "first header", cap[0], "0");
    // R3: table of word patterns against the first sector's lines
    for (int i = 0; i < 8; i++) begin
      logic [47:0] got, want;
      want = {VEC[i].txt, 8'h0D, 8'h0A};
      for (int k = 0; k < 6; k++) got[47 - 8 * k -: 8] = cap[7 + 6 * i + k];
      chk(got == want, "R3", $sformatf("word line %0d", i), got, want);
    end
    // R9: reset in the middle of a walk
    mon_on = 0;
    start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    rst = 1;
    @(negedge clk);
    #1 chk(!tx_valid && !rd_req && !done, "R9", "reset mid-walk", tx_valid, 0);
    @(negedge clk); rst = 0;
    repeat (10) begin
      @(negedge clk);
      #1 chk(!tx_valid && !rd_req, "R9", "idle after reset", tx_valid, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule